// File: doc/BRIEF.md
# Init-Locked Supervisory Watchdog

This block is a start-up-supervised watchdog for a processor subsystem. It is enabled by reset with no software action and holds a 16-bit up-counter that advances on ticks from a prescaler. The prescaler divides the system clock by 2 or by 128. When the counter steps past its all-ones value, the block raises a one-cycle internal reset request. It also drives a registered active-low reset output low for a fixed number of clocks.

Software keeps the system alive by servicing the watchdog. A service copies an 8-bit reload value into the upper byte of the counter and clears the lower byte, so the reload value sets the timeout. A service counts only if the control register was written since the last accepted service. Software may switch the watchdog off, but only until it signals the end of initialisation. From then until the next reset, requests to switch it off are ignored.

Top module: `wdt_supervisor`

## Requirements
- R1: After reset, `count` is 0000h, `rst_out_n` is 1 and `rst_req` is 0. The watchdog is running, and `count` rises by exactly one on each prescaler tick.
- R2: The prescale select bit is written through `ctl_wr` with `ctl_slow`. The value 0 gives one tick every 2 clocks and 1 gives one tick every 128 clocks. The bit resets to 0.
- R3: An accepted service loads `count[15:8]` from the reload register and `count[7:0]` with 00h, visible right after the service edge. It also restarts the prescaler phase, so the next increment comes exactly 2 or 128 clocks after the service edge.
- R4: `svc` is accepted only if a `ctl_wr` has occurred since the last accepted service or reset. An unaccepted `svc` leaves `count` counting as if no strobe had come.
- R5: `reload_wr` stores `reload_din` in the reload register, which resets to 00h.
- R6: An overflow happens on the tick seen at `count` = FFFFh, that is (65536 − 256·reload) × divisor clocks after the service edge. On that edge `rst_req` goes high for exactly one cycle, and `rst_out_n` goes low for exactly 16 cycles.
- R7: While `rst_out_n` is low, `count` stays 0000h and every control input is ignored. When the pulse ends, the reload register, prescale select, init lock and arm flag hold their reset values, and counting resumes with the watchdog running.
- R8: A `dis_req` accepted while the init lock is clear stops counting, and `count` holds its value. The watchdog stays off until reset.
- R9: An `init_done` strobe sets the init lock, which stays set until reset or an overflow pulse. A `dis_req` seen while the lock is set has no effect.
- R10: If an accepted service and an overflow fall on the same edge, the overflow is taken, and `count` goes to 0000h with the reset pulse started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe, arms the next service |
| ctl_slow | input | 1 | Prescale select written by `ctl_wr` (0: /2, 1: /128) |
| reload_wr | input | 1 | Reload register write strobe |
| reload_din | input | 8 | Reload value for the counter's upper byte |
| svc | input | 1 | Service strobe |
| dis_req | input | 1 | Request to switch the watchdog off |
| init_done | input | 1 | End-of-initialisation strobe, sets the lock |
| count | output | 16 | Current counter value |
| rst_req | output | 1 | One-cycle internal reset request on overflow |
| rst_out_n | output | 1 | Registered active-low reset output |

## Verification
A service taken on one rising edge shows in `count` on that same edge. The first increment follows exactly 2 or 128 edges later. `rst_out_n` falls, and `rst_req` rises, on the edge (65536 − 256·reload) × divisor after the service edge. `rst_out_n` then stays low for 16 edges, and counting restarts two edges after it rises. The bench drives every strobe on a falling edge for a single rising edge and samples at the following falling edges, counting edges from the service. Each expected value is therefore tied to a known edge number. The overflow-priority case aims its service strobe at exactly edge 512 after a service with reload FFh in divide-by-2 mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // True when v is a nonzero power of two
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
   import wdt_pkg::*;
#(
   parameter int unsigned DIV_FAST = 2,
   parameter int unsigned DIV_SLOW = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   input  logic slow,
   output logic tick
);

   localparam int unsigned PRE_W = $clog2(DIV_SLOW);

   logic [PRE_W-1:0] pre_q;

   generate
      if (is_pow2(DIV_FAST) && is_pow2(DIV_SLOW)) begin : g_tap
         // Power-of-two divisors: free-running count, tick when the low bits are all ones
         localparam logic [PRE_W-1:0] MASK_F = PRE_W'(DIV_FAST - 1);
         localparam logic [PRE_W-1:0] MASK_S = PRE_W'(DIV_SLOW - 1);
         logic [PRE_W-1:0] mask;
         assign mask = slow ? MASK_S : MASK_F;
         assign tick = run && ((pre_q & mask) == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pre_q <= '0;
            else if (clr)   pre_q <= '0;
            else if (run)   pre_q <= pre_q + PRE_W'(1);
         end
      end else begin : g_cmp
         // General divisors: compare against the limit and restart
         logic [PRE_W-1:0] lim;
         assign lim  = slow ? PRE_W'(DIV_SLOW - 1) : PRE_W'(DIV_FAST - 1);
         assign tick = run && (pre_q >= lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pre_q <= '0;
            else if (clr)   pre_q <= '0;
            else if (run)   pre_q <= tick ? '0 : pre_q + PRE_W'(1);
         end
      end
   endgenerate

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick) else $error("tick on consecutive cycles");  // R2

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned RLD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             tick,
   input  logic             svc_ok,
   input  logic [RLD_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   localparam int unsigned LOW_W = CNT_W - RLD_W;

   logic [CNT_W-1:0] cnt_q;

   assign ovf   = tick && (&cnt_q) && !hold;
   assign count = cnt_q;

   // Overflow outranks service; the hold pulse outranks everything
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (hold || ovf)    cnt_q <= '0;
      else if (svc_ok)         cnt_q <= {reload, {LOW_W{1'b0}}};
      else if (tick)           cnt_q <= cnt_q + CNT_W'(1);
   end

   AST_SVC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_ok && !ovf && !hold) |=> (cnt_q[LOW_W-1:0] == '0) && (cnt_q[CNT_W-1:LOW_W] == $past(reload)))
      else $error("service load wrong");  // R3
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ovf && !svc_ok && !hold) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)))
      else $error("counter step wrong");  // R1
   AST_OVF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt_q == '0)) else $error("overflow did not clear counter");  // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !svc_ok && !hold) |=> $stable(cnt_q)) else $error("counter moved without tick");  // R8

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
   parameter int unsigned RLD_W     = 8,
   parameter int unsigned PULSE_LEN = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             ctl_slow,
   input  logic             reload_wr,
   input  logic [RLD_W-1:0] reload_din,
   input  logic             svc,
   input  logic             dis_req,
   input  logic             init_done,
   input  logic             ovf,
   output logic             hold,
   output logic             run,
   output logic             svc_ok,
   output logic             slow,
   output logic [RLD_W-1:0] reload,
   output logic             rst_req,
   output logic             rst_out_n
);

   localparam int unsigned PW = $clog2(PULSE_LEN + 1);

   logic [PW-1:0]    pulse_q, pulse_d;
   logic             en_q, lock_q, armed_q, slow_q, req_q, out_q;
   logic [RLD_W-1:0] reload_q;

   assign hold      = (pulse_q != '0);
   assign run       = en_q && !hold;
   assign svc_ok    = svc && armed_q && !hold;
   assign slow      = slow_q;
   assign reload    = reload_q;
   assign rst_req   = req_q;
   assign rst_out_n = out_q;

   assign pulse_d = ovf  ? PW'(PULSE_LEN) :
                    hold ? pulse_q - PW'(1) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q  <= '0;
         out_q    <= 1'b1;
         req_q    <= 1'b0;
         en_q     <= 1'b1;
         lock_q   <= 1'b0;
         armed_q  <= 1'b0;
         slow_q   <= 1'b0;
         reload_q <= '0;
      end else begin
         pulse_q <= pulse_d;
         out_q   <= (pulse_d == '0);
         req_q   <= ovf;
         if (hold) begin
            en_q     <= 1'b1;
            lock_q   <= 1'b0;
            armed_q  <= 1'b0;
            slow_q   <= 1'b0;
            reload_q <= '0;
         end else begin
            if (reload_wr)            reload_q <= reload_din;
            if (ctl_wr)               slow_q   <= ctl_slow;
            if (svc_ok)               armed_q  <= 1'b0;
            else if (ctl_wr)          armed_q  <= 1'b1;
            if (init_done)            lock_q   <= 1'b1;
            if (dis_req && !lock_q)   en_q     <= 1'b0;
         end
      end
   end

   AST_REQ_START: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (rst_req && !rst_out_n)) else $error("overflow gave no reset");  // R6
   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req) else $error("reset request longer than one cycle");  // R6
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !hold) |=> lock_q) else $error("lock dropped");  // R9
   AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && en_q && !hold) |=> en_q) else $error("disabled after lock");  // R9
   AST_OFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !hold) |=> !en_q) else $error("watchdog re-enabled");  // R8
   AST_PULSE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !armed_q) else $error("armed during pulse");  // R7

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned RLD_W     = 8,
   parameter int unsigned DIV_FAST  = 2,
   parameter int unsigned DIV_SLOW  = 128,
   parameter int unsigned PULSE_LEN = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             ctl_slow,
   input  logic             reload_wr,
   input  logic [RLD_W-1:0] reload_din,
   input  logic             svc,
   input  logic             dis_req,
   input  logic             init_done,
   output logic [CNT_W-1:0] count,
   output logic             rst_req,
   output logic             rst_out_n
);

   generate
      if (RLD_W == 0 || RLD_W >= CNT_W) begin : g_bad_width
         $error("RLD_W must be between 1 and CNT_W-1");
      end
      if (DIV_FAST < 2 || DIV_SLOW <= DIV_FAST) begin : g_bad_div
         $error("need 2 <= DIV_FAST < DIV_SLOW");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("PULSE_LEN must be at least 1");
      end
   endgenerate

   logic             hold, run, svc_ok, slow, tick, ovf;
   logic [RLD_W-1:0] reload;

   wdt_ctrl #(.RLD_W(RLD_W), .PULSE_LEN(PULSE_LEN)) u_ctrl (
      .clk, .rst_n, .ctl_wr, .ctl_slow, .reload_wr, .reload_din,
      .svc, .dis_req, .init_done, .ovf,
      .hold, .run, .svc_ok, .slow, .reload, .rst_req, .rst_out_n
   );

   wdt_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
      .clk, .rst_n, .run, .clr(hold || svc_ok), .slow, .tick
   );

   wdt_counter #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_cnt (
      .clk, .rst_n, .hold, .tick, .svc_ok, .reload, .count, .ovf
   );

   AST_PULSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_out_n |-> (count == '0)) else $error("count nonzero during pulse");  // R7

endmodule

// File: tb/wdt_supervisor_test.sv
module wdt_supervisor_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0, ctl_slow = 1'b0, reload_wr = 1'b0;
   logic [7:0]  reload_din = '0;
   logic        svc = 1'b0, dis_req = 1'b0, init_done = 1'b0;
   logic [15:0] count;
   logic        rst_req, rst_out_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdt_supervisor uut (
      .clk, .rst_n, .ctl_wr, .ctl_slow, .reload_wr, .reload_din,
      .svc, .dis_req, .init_done, .count, .rst_req, .rst_out_n
   );

   function automatic int exp_timeout(input int r, input bit slw);
      return (65536 - 256 * r) * (slw ? 128 : 2);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ctl(input bit s);
      ctl_slow = s; ctl_wr = 1'b1; @(negedge clk); ctl_wr = 1'b0;
   endtask
   task automatic wr_reload(input logic [7:0] v);
      reload_din = v; reload_wr = 1'b1; @(negedge clk); reload_wr = 1'b0;
   endtask
   task automatic service();
      svc = 1'b1; @(negedge clk); svc = 1'b0;
   endtask
   task automatic do_reset();
      rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
   endtask

   // Edges after the service edge until rst_out_n is seen low
   task automatic wait_low(output int m);
      m = 0;
      while (rst_out_n && m < 200000) begin @(negedge clk); m++; end
   endtask

   // Called on the first falling edge with rst_out_n low
   task automatic check_pulse();
      int low = 1;
      check(rst_req == 1'b1, "R6 rst_req at overflow", int'(rst_req), 1);
      svc = 1'b1; ctl_wr = 1'b1; ctl_slow = 1'b1; reload_wr = 1'b1;
      reload_din = 8'h55; dis_req = 1'b1;
      for (int i = 0; i < 40 && !rst_out_n; i++) begin
         @(negedge clk);
         if (!rst_out_n) begin
            low++;
            if (count != 16'h0) check(1'b0, "R7 count in pulse", int'(count), 0);
            if (rst_req)        check(1'b0, "R6 rst_req single", 1, 0);
         end
      end
      svc = 1'b0; ctl_wr = 1'b0; ctl_slow = 1'b0; reload_wr = 1'b0; dis_req = 1'b0;
      check(low == 16, "R6 pulse length", low, 16);
      repeat (2) @(negedge clk);
      check(count == 16'h1, "R7 running at /2 after pulse", int'(count), 1);
      service();
      check(count != 16'h0, "R7 arm cleared by pulse", int'(count), 1);
      ctl(1'b0); service();
      check(count == 16'h0, "R5 R7 reload back to 00h", int'(count), 0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int m, r, c;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(count == 16'h0, "R1 reset count", int'(count), 0);
      check(rst_out_n == 1'b1, "R1 reset rst_out_n", int'(rst_out_n), 1);
      check(rst_req == 1'b0, "R1 reset rst_req", int'(rst_req), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check(count == 16'd5, "R1 R2 running at /2 from reset", int'(count), 5);

      // R4 unarmed service ignored
      wr_reload(8'h80);
      c = int'(count);
      service();
      check(int'(count) == c || int'(count) == c + 1, "R4 unarmed service", int'(count), c);
      ctl(1'b0); service();
      check(count == 16'h8000, "R3 R5 service load", int'(count), 32'h8000);
      @(negedge clk);
      check(count == 16'h8000, "R3 no step before 2 clocks", int'(count), 32'h8000);
      @(negedge clk);
      check(count == 16'h8001, "R3 step at 2 clocks", int'(count), 32'h8001);
      service();
      check(count != 16'h8000, "R4 second service unarmed", int'(count), 32'h8001);

      // R2 divide by 128
      ctl(1'b1); service();
      repeat (127) @(negedge clk);
      check(count == 16'h8000, "R2 no step before 128", int'(count), 32'h8000);
      @(negedge clk);
      check(count == 16'h8001, "R2 step at 128", int'(count), 32'h8001);
      repeat (128) @(negedge clk);
      check(count == 16'h8002, "R2 second step at 256", int'(count), 32'h8002);

      // R6 random reload timeouts at /2
      for (int k = 0; k < 4; k++) begin
         r = 224 + int'($urandom % 32);
         wr_reload(r[7:0]); ctl(1'b0); service();
         check(count == {r[7:0], 8'h00}, "R3 random load", int'(count), r * 256);
         wait_low(m);
         check(m == exp_timeout(r, 1'b0), "R6 timeout /2", m, exp_timeout(r, 1'b0));
         check_pulse();
      end

      // R6 timeout at /128 with reload FFh
      wr_reload(8'hFF); ctl(1'b1); service();
      wait_low(m);
      check(m == exp_timeout(255, 1'b1), "R6 timeout /128", m, exp_timeout(255, 1'b1));
      check_pulse();

      // R10 service on the overflow edge
      wr_reload(8'hFF); ctl(1'b0); service();
      ctl(1'b0);
      repeat (510) @(negedge clk);
      svc = 1'b1; @(negedge clk); svc = 1'b0;
      check(rst_out_n == 1'b0, "R10 overflow wins rst_out_n", int'(rst_out_n), 0);
      check(count == 16'h0, "R10 overflow wins count", int'(count), 0);
      check_pulse();

      // R8 disable before init lock
      dis_req = 1'b1; @(negedge clk); dis_req = 1'b0;
      c = int'(count);
      repeat (50) @(negedge clk);
      check(int'(count) == c, "R8 disabled count holds", int'(count), c);
      check(rst_out_n == 1'b1, "R8 no reset while off", int'(rst_out_n), 1);

      // R9 disable after init lock ignored
      do_reset();
      init_done = 1'b1; @(negedge clk); init_done = 1'b0;
      dis_req = 1'b1; @(negedge clk); dis_req = 1'b0;
      wr_reload(8'hFF); ctl(1'b0); service();
      wait_low(m);
      check(m == 512, "R9 disable ignored after lock", m, 512);
      check_pulse();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule